// File: doc/BRIEF.md
# Edge-Latched Status and Interrupt Register Bank

This block keeps a set of monitored status signals visible to a host through a small register window. Each monitored line is first brought into the local clock domain. Its current level can then be read directly. A sticky copy records the chosen transitions of the line, and a mask decides which sticky bits may pull the shared interrupt line low. A live bit, its sticky copy and its mask bit all use the same bit index, so host code can test one bit position across the live, sticky and mask registers.

Each sticky bit has its own edge rule, fixed by a parameter: rising, falling or any change. The host clears a sticky bit by writing a one to that position. A second, auxiliary register holds a mix of live and sticky bits, and none of them can raise an interrupt. This bank's request is combined with requests from other blocks to form the single active-low interrupt output.

Top module: `stat_irq_bank`

## Requirements
- R1: Offset 0 returns the monitored inputs after a two-flop synchronizer, masked to the live positions (default bits 0, 1, 2, 5, 6). A level change is readable two clock edges after it is driven.
- R2: A sticky bit at offset 1 sets on the third clock edge after its input changes, and only if the change matches the bit's edge rule. The default rules are bit 0 any change, bits 1 to 3 rising, bit 5 falling, and bit 6 any change. A change that does not match the rule leaves the bit clear.
- R3: Writing to offset 1 clears each sticky bit whose write-data bit is 1. Bits written with 0 keep their value. A cleared bit stays clear until a new qualifying edge.
- R4: If a qualifying edge and a write-one clear of the same bit fall in the same cycle, the bit ends up set.
- R5: The mask register at offset 2 resets to 0, can be written, and reads back only at sticky positions (default mask 0x6F).
- R6: The interrupt output is low while any sticky bit and its mask bit are both 1. It is high when no such pair exists and no external request is active.
- R7: Bit 3 is sticky-only: offset 0 reads 0 at bit 3 even while its input is high, and offset 1 still latches its rising edge.
- R8: Offset 3 returns live bits 0 and 1, a sticky rising-edge bit 2 and a sticky falling-edge bit 3. Its sticky bits are cleared by writing ones to offset 3, and no value of offset 3 ever moves the interrupt output.
- R9: Any external request input at 1 drives the interrupt output low in the same cycle.
- R10: After reset every register reads 0 and the interrupt output is high.
- R11: Positions that are neither live nor sticky (default bits 4 and 7) read 0 at every offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mon_i | input | W | Monitored status lines of the main bank |
| info_mon_i | input | W | Monitored lines of the auxiliary register |
| ext_irq_i | input | N_EXT | Active-high requests from other sources |
| reg_addr | input | 2 | Register offset |
| reg_wr | input | 1 | Write strobe, taken on the clock edge |
| reg_wdata | input | W | Write data |
| reg_rdata | output | W | Read data for reg_addr, combinational |
| irq_n_o | output | 1 | Shared interrupt, active low |

## Verification
The main bank is driven with all lines rising together, then all lines falling together. The sticky result then shows whether each bit's rising and falling sensitivity is correct on its own, which a single toggle pattern cannot separate. A mixed pattern (0xA5) on the live register separates bits that are masked out from bits that are passed through. A write-zero, a partial clear and a clear placed in the exact cycle of an edge separate a plain clear from the rule that a new edge wins over the clear. The auxiliary register and the external requests are exercised with every mask bit set. This shows that the auxiliary bits leave the interrupt alone while an external request still pulls it low.

// File: rtl/stat_irq_pkg.sv
package stat_irq_pkg;

   localparam int unsigned ADDR_W = 2;

   typedef enum logic [ADDR_W-1:0] {
      OFS_LIVE   = 2'd0,
      OFS_LATCH  = 2'd1,
      OFS_ENABLE = 2'd2,
      OFS_INFO   = 2'd3
   } reg_ofs_e;

   // two-bit edge rule per sticky bit
   localparam logic [1:0] EDGE_NONE = 2'b00;
   localparam logic [1:0] EDGE_RISE = 2'b01;
   localparam logic [1:0] EDGE_FALL = 2'b10;
   localparam logic [1:0] EDGE_ANY  = 2'b11;

endpackage

// File: rtl/stat_irq_sync.sv
module stat_irq_sync #(
   parameter int unsigned W      = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   localparam int unsigned LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("stat_irq_sync: STAGES must be at least 2");
   end

   logic [W-1:0] chain_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < int'(STAGES); s++) chain_q[s] <= '0;
      end else begin
         chain_q[0] <= d_i;
         for (int s = 1; s < int'(STAGES); s++) chain_q[s] <= chain_q[s-1];
      end
   end

   assign q_o = chain_q[LAST];
endmodule

// File: rtl/stat_irq_latch.sv
module stat_irq_latch
   import stat_irq_pkg::*;
#(
   parameter int unsigned       W          = 8,
   parameter logic [W-1:0]      LATCH_MASK = '0,
   parameter logic [2*W-1:0]    EDGE_SEL   = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] lat_o,
   output logic [W-1:0] evt_o
);
   logic [W-1:0] rise_en;
   logic [W-1:0] fall_en;
   logic [W-1:0] prev_q;
   logic [W-1:0] lat_q;
   logic [W-1:0] rise;
   logic [W-1:0] fall;

   for (genvar i = 0; i < int'(W); i++) begin : g_bit
      localparam logic [1:0] SEL = EDGE_SEL[2*i +: 2];
      if (LATCH_MASK[i] && SEL == EDGE_NONE) begin : g_no_rule
         $error("stat_irq_latch: sticky bit without an edge rule");
      end
      if (!LATCH_MASK[i] && SEL != EDGE_NONE) begin : g_stray_rule
         $error("stat_irq_latch: edge rule on a non-sticky bit");
      end
      if (SEL == EDGE_ANY) begin : g_any
         assign rise_en[i] = 1'b1;
         assign fall_en[i] = 1'b1;
      end else if (SEL == EDGE_RISE) begin : g_rise
         assign rise_en[i] = 1'b1;
         assign fall_en[i] = 1'b0;
      end else if (SEL == EDGE_FALL) begin : g_fall
         assign rise_en[i] = 1'b0;
         assign fall_en[i] = 1'b1;
      end else begin : g_none
         assign rise_en[i] = 1'b0;
         assign fall_en[i] = 1'b0;
      end
   end

   assign rise  = lvl_i & ~prev_q;
   assign fall  = ~lvl_i & prev_q;
   assign evt_o = ((rise & rise_en) | (fall & fall_en)) & LATCH_MASK;

   // a fresh edge outranks a simultaneous clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         lat_q  <= '0;
      end else begin
         prev_q <= lvl_i;
         lat_q  <= ((lat_q & ~clr_i) | evt_o) & LATCH_MASK;
      end
   end

   assign lat_o = lat_q;
endmodule

// File: rtl/stat_irq_combine.sv
module stat_irq_combine #(
   parameter int unsigned W     = 8,
   parameter int unsigned N_EXT = 2
) (
   input  logic [W-1:0]     lat_i,
   input  logic [W-1:0]     en_i,
   input  logic [N_EXT-1:0] ext_i,
   output logic             bank_req_o,
   output logic             irq_n_o
);
   if (N_EXT < 1) begin : g_bad_ext
      $error("stat_irq_combine: N_EXT must be at least 1");
   end

   logic ext_any;

   assign bank_req_o = |(lat_i & en_i);
   assign ext_any    = |ext_i;
   assign irq_n_o    = ~(bank_req_o | ext_any);
endmodule

// File: rtl/stat_irq_bank.sv
module stat_irq_bank
   import stat_irq_pkg::*;
#(
   parameter int unsigned    W               = 8,
   parameter int unsigned    N_EXT           = 2,
   parameter int unsigned    SYNC_STAGES     = 2,
   parameter logic [W-1:0]   LIVE_MASK       = 8'b0110_0111,
   parameter logic [W-1:0]   LATCH_MASK      = 8'b0110_1111,
   parameter logic [2*W-1:0] EDGE_SEL        = 16'b00_11_10_00_01_01_01_11,
   parameter logic [W-1:0]   INFO_LIVE_MASK  = 8'b0000_0011,
   parameter logic [W-1:0]   INFO_LATCH_MASK = 8'b0000_1100,
   parameter logic [2*W-1:0] INFO_EDGE_SEL   = 16'b00_00_00_00_10_01_00_00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [W-1:0]      mon_i,
   input  logic [W-1:0]      info_mon_i,
   input  logic [N_EXT-1:0]  ext_irq_i,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [W-1:0]      reg_wdata,
   output logic [W-1:0]      reg_rdata,
   output logic              irq_n_o
);
   if (W < 1 || W > 32) begin : g_bad_width
      $error("stat_irq_bank: W must lie in 1..32");
   end
   if ((INFO_LIVE_MASK & INFO_LATCH_MASK) != '0) begin : g_info_overlap
      $error("stat_irq_bank: an auxiliary bit cannot be both live and sticky");
   end

   logic [W-1:0] mon_s;
   logic [W-1:0] info_s;
   logic [W-1:0] lat_q;
   logic [W-1:0] evt;
   logic [W-1:0] info_lat;
   logic [W-1:0] info_evt;
   logic [W-1:0] en_q;
   logic [W-1:0] clr_main;
   logic [W-1:0] clr_info;
   logic         bank_req;
   logic         wr_latch;
   logic         wr_info;
   logic         wr_enable;

   stat_irq_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync_main (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (mon_i),
      .q_o   (mon_s)
   );

   stat_irq_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync_info (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (info_mon_i),
      .q_o   (info_s)
   );

   assign wr_latch  = reg_wr && (reg_addr == OFS_LATCH);
   assign wr_info   = reg_wr && (reg_addr == OFS_INFO);
   assign wr_enable = reg_wr && (reg_addr == OFS_ENABLE);
   assign clr_main  = wr_latch ? reg_wdata : '0;
   assign clr_info  = wr_info  ? reg_wdata : '0;

   stat_irq_latch #(.W(W), .LATCH_MASK(LATCH_MASK), .EDGE_SEL(EDGE_SEL)) u_latch_main (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl_i (mon_s),
      .clr_i (clr_main),
      .lat_o (lat_q),
      .evt_o (evt)
   );

   stat_irq_latch #(.W(W), .LATCH_MASK(INFO_LATCH_MASK), .EDGE_SEL(INFO_EDGE_SEL)) u_latch_info (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl_i (info_s),
      .clr_i (clr_info),
      .lat_o (info_lat),
      .evt_o (info_evt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= '0;
      end else if (wr_enable) begin
         en_q <= reg_wdata & LATCH_MASK;
      end
   end

   always_comb begin
      unique case (reg_addr)
         OFS_LIVE:   reg_rdata = mon_s & LIVE_MASK;
         OFS_LATCH:  reg_rdata = lat_q;
         OFS_ENABLE: reg_rdata = en_q;
         OFS_INFO:   reg_rdata = (info_s & INFO_LIVE_MASK) | info_lat;
         default:    reg_rdata = '0;
      endcase
   end

   // auxiliary bits are deliberately kept out of the request path
   stat_irq_combine #(.W(W), .N_EXT(N_EXT)) u_combine (
      .lat_i      (lat_q),
      .en_i       (en_q),
      .ext_i      (ext_irq_i),
      .bank_req_o (bank_req),
      .irq_n_o    (irq_n_o)
   );

   logic unused_evt;
   assign unused_evt = ^{info_evt, bank_req};
endmodule

// File: rtl/stat_irq_bank_chk.sv
module stat_irq_bank_chk #(
   parameter int unsigned  W          = 8,
   parameter int unsigned  N_EXT      = 2,
   parameter logic [W-1:0] LATCH_MASK = '0
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       reg_addr,
   input logic             reg_wr,
   input logic [W-1:0]     reg_wdata,
   input logic [W-1:0]     reg_rdata,
   input logic [N_EXT-1:0] ext_irq_i,
   input logic             irq_n_o,
   input logic [W-1:0]     lat_q,
   input logic [W-1:0]     en_q,
   input logic [W-1:0]     evt,
   input logic [W-1:0]     clr_main
);
   // R3: a clear written without a competing edge takes effect
   a_r3_clear_applies: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == 2'd1) |=> ((lat_q & $past(reg_wdata) & ~$past(evt)) == '0));

   // R4: an edge leaves its bit set even under a clear
   a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (|evt) |=> ((lat_q & $past(evt)) == $past(evt)));

   // R2: sticky bits move only by an edge or a clear
   a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (((lat_q ^ $past(lat_q)) & ~$past(evt) & ~$past(clr_main)) == '0));

   // R5: mask write reads back restricted to sticky positions
   a_r5_mask_readback: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == 2'd2) |=> (reg_addr != 2'd2 || reg_rdata == ($past(reg_wdata) & LATCH_MASK)));

   // R6: an enabled sticky bit pulls the line low
   a_r6_irq_low: assert property (@(posedge clk) disable iff (!rst_n)
      (|(lat_q & en_q)) |-> !irq_n_o);

   // R8: with no enabled main request and no external one, the line stays high
   a_r8_info_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
      (((lat_q & en_q) == '0) && !(|ext_irq_i)) |-> irq_n_o);

   // R9: external requests reach the line
   a_r9_ext_irq: assert property (@(posedge clk) disable iff (!rst_n)
      (|ext_irq_i) |-> !irq_n_o);
endmodule

bind stat_irq_bank stat_irq_bank_chk #(
   .W          (W),
   .N_EXT      (N_EXT),
   .LATCH_MASK (LATCH_MASK)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_addr  (reg_addr),
   .reg_wr    (reg_wr),
   .reg_wdata (reg_wdata),
   .reg_rdata (reg_rdata),
   .ext_irq_i (ext_irq_i),
   .irq_n_o   (irq_n_o),
   .lat_q     (lat_q),
   .en_q      (en_q),
   .evt       (evt),
   .clr_main  (clr_main)
);

// File: tb/stat_irq_bank_tb_top.sv
`timescale 1ns/1ps
module stat_irq_bank_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] mon_i = '0;
   logic [7:0] info_mon_i = '0;
   logic [1:0] ext_irq_i = '0;
   logic [1:0] reg_addr = '0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       irq_n_o;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #2.5 clk = ~clk;

   stat_irq_bank dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .mon_i      (mon_i),
      .info_mon_i (info_mon_i),
      .ext_irq_i  (ext_irq_i),
      .reg_addr   (reg_addr),
      .reg_wr     (reg_wr),
      .reg_wdata  (reg_wdata),
      .reg_rdata  (reg_rdata),
      .irq_n_o    (irq_n_o)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] v);
      @(negedge clk);
      reg_addr = a;
      #1 v = reg_rdata;
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr  = a;
      reg_wdata = d;
      reg_wr    = 1'b1;
      @(posedge clk);
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   // sync (2) plus edge register (1): sticky result visible after three edges
   task automatic drive_mon(input logic [7:0] v);
      @(negedge clk);
      mon_i = v;
      repeat (3) @(posedge clk);
   endtask

   task automatic drive_info(input logic [7:0] v);
      @(negedge clk);
      info_mon_i = v;
      repeat (3) @(posedge clk);
   endtask

   task automatic t_reset();
      logic [7:0] v;
      for (int a = 0; a < 4; a++) begin
         rd(a[1:0], v);
         chk("R10 reset register", v, 8'h00);
      end
      chk("R10 reset irq", {7'b0, irq_n_o}, 8'h01);
   endtask

   task automatic t_live();
      logic [7:0] v;
      drive_mon(8'hFF);
      rd(2'd0, v);
      chk("R1 live all high", v, 8'h67);
      chk("R11 unused bits live", v & 8'h90, 8'h00);
      chk("R7 sticky-only bit absent from live", v & 8'h08, 8'h00);
      drive_mon(8'hA5);
      rd(2'd0, v);
      chk("R1 live mixed pattern", v, 8'h25);
      drive_mon(8'h00);
      wr(2'd1, 8'hFF);
      rd(2'd1, v);
      chk("R3 clear all", v, 8'h00);
   endtask

   task automatic t_edges();
      logic [7:0] v;
      drive_mon(8'hFF);
      rd(2'd1, v);
      chk("R2 rising-capable bits", v, 8'h4F);
      chk("R7 sticky-only bit latches", v & 8'h08, 8'h08);
      chk("R11 unused bits sticky", v & 8'h90, 8'h00);
      wr(2'd1, 8'h00);
      rd(2'd1, v);
      chk("R3 write zero keeps", v, 8'h4F);
      wr(2'd1, 8'h01);
      rd(2'd1, v);
      chk("R3 partial clear", v, 8'h4E);
      wr(2'd1, 8'hFF);
      repeat (3) @(posedge clk);
      rd(2'd1, v);
      chk("R3 stays clear without edge", v, 8'h00);
      drive_mon(8'h00);
      rd(2'd1, v);
      chk("R2 falling-capable bits", v, 8'h61);
      wr(2'd1, 8'hFF);
   endtask

   task automatic t_set_wins();
      logic [7:0] v;
      drive_mon(8'h02);   // bit1 latched
      @(negedge clk);
      mon_i = 8'h03;      // bit0 rise
      @(posedge clk);
      @(negedge clk);
      @(posedge clk);     // edge now pending for bit0
      @(negedge clk);
      reg_addr  = 2'd1;
      reg_wdata = 8'h03;
      reg_wr    = 1'b1;
      @(posedge clk);
      @(negedge clk);
      reg_wr = 1'b0;
      rd(2'd1, v);
      chk("R4 edge beats clear", v, 8'h01);
      drive_mon(8'h00);
      wr(2'd1, 8'hFF);
      rd(2'd1, v);
      chk("R3 cleared after set-wins", v, 8'h00);
   endtask

   task automatic t_enable();
      logic [7:0] v;
      wr(2'd2, 8'hFF);
      rd(2'd2, v);
      chk("R5 mask readback", v, 8'h6F);
      chk("R11 unused bits mask", v & 8'h90, 8'h00);
      wr(2'd2, 8'h00);
      rd(2'd2, v);
      chk("R5 mask cleared", v, 8'h00);
   endtask

   task automatic t_irq();
      wr(2'd2, 8'h02);
      #1 chk("R6 idle high", {7'b0, irq_n_o}, 8'h01);
      drive_mon(8'h01);   // bit0 sets, not enabled
      #1 chk("R6 masked bit no irq", {7'b0, irq_n_o}, 8'h01);
      drive_mon(8'h03);   // bit1 rises, enabled
      #1 chk("R6 enabled bit irq", {7'b0, irq_n_o}, 8'h00);
      wr(2'd1, 8'h02);
      #1 chk("R6 released on clear", {7'b0, irq_n_o}, 8'h01);
      drive_mon(8'h00);
      wr(2'd1, 8'hFF);
   endtask

   task automatic t_info();
      logic [7:0] v;
      wr(2'd2, 8'hFF);
      drive_info(8'h03);
      rd(2'd3, v);
      chk("R8 info live bits", v, 8'h03);
      drive_info(8'h0F);
      rd(2'd3, v);
      chk("R8 info rise latch", v, 8'h07);
      chk("R8 info no irq", {7'b0, irq_n_o}, 8'h01);
      drive_info(8'h00);
      rd(2'd3, v);
      chk("R8 info fall latch", v, 8'h0C);
      wr(2'd3, 8'h04);
      rd(2'd3, v);
      chk("R8 info partial clear", v, 8'h08);
      chk("R8 info no irq latched", {7'b0, irq_n_o}, 8'h01);
      wr(2'd3, 8'h08);
      rd(2'd3, v);
      chk("R8 info cleared", v, 8'h00);
   endtask

   task automatic t_ext();
      @(negedge clk);
      ext_irq_i = 2'b01;
      #1 chk("R9 ext source 0", {7'b0, irq_n_o}, 8'h00);
      ext_irq_i = 2'b10;
      #1 chk("R9 ext source 1", {7'b0, irq_n_o}, 8'h00);
      ext_irq_i = 2'b00;
      #1 chk("R9 ext released", {7'b0, irq_n_o}, 8'h01);
   endtask

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(posedge clk);
      t_reset();
      t_live();
      t_edges();
      t_set_wins();
      t_enable();
      t_irq();
      t_info();
      t_ext();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      #500000;
      if (!done) begin
         done = 1'b1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule